// File: doc/BRIEF.md
# Host Bridge Configuration Register Port

This block holds the 256-byte configuration space of a host-to-PCI bridge and gives a processor two ways into it. A direct window takes byte, halfword and word accesses addressed by an 8-bit offset. An indirect pair of ports lets software first write an address port and then read or write a data port. An address-port write either selects an internal register offset, or is forwarded over a small request/response handshake to an external configuration-bus responder.

A 4-byte data buffer is filled when the address port is written. It is filled from the register file for an internal access, or from the responder's reply for a forwarded one. Data-port reads return bytes of this buffer. Data-port writes update the register file at the latched offset and also update the buffer. Reset loads a built-in image of identification and configuration values. A strap input picks one of two device variants.

Top module: `hbcfg_port`

## Requirements
- R1: While `rstN` is low at a clock edge, the register file takes its reset image. Every byte is zero except these: bytes 0x00..0x01 = 0x10,0x57; bytes 0x02..0x03 = 0x00 followed by 0x01 (strap `variantSel`=0) or 0x02 (strap 1); bytes 0x04..0x05 = 0x00,0x06; bytes 0x06..0x07 = 0x00,0x80; byte 0x0B = 0x06; bytes 0xF0..0xF1 = 0xFF,0x02.
- R2: When `variantSel`=1 during reset, the image also holds byte 0x0C = 0x08, byte 0x73 = 0xCD, bytes 0xE0..0xE3 = 0x0F,0xFF,0x00,0x42 and byte 0xEB = 0x20.
- R3: Direct accesses use a size code (0 byte, 1 halfword, 2 word). The base address is `dirAddr` with bit 0 cleared for a halfword and bits 1:0 cleared for a word. Data sits in the low bits of `dirWdata`/`dirRdata`, with the lowest address holding the most significant byte. Unused high read bits are zero. Reads are combinational, and writes take effect at the clock edge where `dirValid` and `dirWrite` are high.
- R4: An accepted address-port write whose bits 23:0 equal 0x000080 is an internal access. It latches bits 31:24 as the offset and copies register bytes offset+0..offset+3 (modulo 256) into buffer bytes 0..3. The result is visible from the next cycle, and no external request is raised.
- R5: Data-port reads are combinational from the buffer, with buffer byte 0 most significant. A byte read returns buffer byte `dpSub`. A halfword read returns bytes `dpSub[1]*2` and the next one. A word read returns all four bytes.
- R6: A data-port write (`dpValid` and `dpWrite`) stores its bytes at register address offset + aligned sub-offset + k, modulo 256. It also stores the same bytes at buffer byte aligned sub-offset + k.
- R7: An accepted address-port write that is not internal, made while `extPresent` is high, raises `extReqValid` on the next cycle. `extReqData` then carries the written word byte-reversed. Both stay unchanged until `extReqReady` is seen high.
- R8: After the request is taken, the `extRspValid` strobe loads `extRspData` byte-reversed into the buffer (its most significant byte becomes buffer byte 3). It also returns the address port to ready.
- R9: A non-internal address-port write made while `extPresent` is low raises no request and loads 0xFFFFFFFF into the buffer.
- R10: `apReady` is low from the cycle after a forwarded write is accepted until the response arrives. Address-port writes made while it is low have no effect.
- R11: Reset clears the data buffer and the latched offset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| variantSel | input | 1 | Device variant strap, sampled during reset |
| dirValid | input | 1 | Direct window access strobe |
| dirWrite | input | 1 | Direct access is a write |
| dirSize | input | 2 | Direct access size code |
| dirAddr | input | 8 | Direct register offset |
| dirWdata | input | 32 | Direct write data, low-aligned |
| dirRdata | output | 32 | Direct read data, low-aligned |
| apWrValid | input | 1 | Address-port write strobe |
| apWdata | input | 32 | Address-port write value |
| apReady | output | 1 | Address port can accept a write |
| dpValid | input | 1 | Data-port access strobe |
| dpWrite | input | 1 | Data-port access is a write |
| dpSize | input | 2 | Data-port access size code |
| dpSub | input | 2 | Data-port byte sub-offset |
| dpWdata | input | 32 | Data-port write data, low-aligned |
| dpRdata | output | 32 | Data-port read data, low-aligned |
| extPresent | input | 1 | An external responder is attached |
| extReqValid | output | 1 | Forwarded request valid |
| extReqReady | input | 1 | Responder takes the request |
| extReqData | output | 32 | Forwarded address word, byte-reversed |
| extRspValid | input | 1 | Responder reply strobe |
| extRspData | input | 32 | Responder reply word |

## Verification
The assertions assume a well-behaved host and responder. The responder pulses `extRspValid` only after it has taken a request, and never while one is still being offered. The host never drives a data-port write in the cycle it writes the address port. The buffer checks also expect `dpSize` to be a valid code. The stimulus drives one port at a time, raises the response strobe only in the wait phase, and keeps size codes within 0..2. Among the address-port writes it issues are some made while the port is busy, so that R10's ignore path is exercised at the ports.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

  localparam int BUF_BYTES = 4;
  localparam logic [23:0] LOCAL_TAG = 24'h000080;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  typedef struct packed {
    logic latchPtr;
    logic loadFromRegs;
    logic loadFromRsp;
    logic loadAllOnes;
    logic dirWr;
    logic dpWr;
  } strobe_t;

  function automatic logic [31:0] bswap32(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic int laneCount(logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction

  // byte k of a low-aligned, most-significant-first value of the given size
  function automatic logic [7:0] laneByte(logic [31:0] w, logic [1:0] sz, int k);
    int nb;
    nb = laneCount(sz);
    if (k >= nb) return 8'h00;
    return w[8*(nb-1-k) +: 8];
  endfunction

  function automatic logic [7:0] resetByte(logic variantB, int idx);
    case (idx)
      32'h00: return 8'h10;
      32'h01: return 8'h57;
      32'h03: return variantB ? 8'h02 : 8'h01;
      32'h05: return 8'h06;
      32'h07: return 8'h80;
      32'h0B: return 8'h06;
      32'h0C: return variantB ? 8'h08 : 8'h00;
      32'h73: return variantB ? 8'hCD : 8'h00;
      32'hE0: return variantB ? 8'h0F : 8'h00;
      32'hE1: return variantB ? 8'hFF : 8'h00;
      32'hE3: return variantB ? 8'h42 : 8'h00;
      32'hEB: return variantB ? 8'h20 : 8'h00;
      32'hF0: return 8'hFF;
      32'hF1: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/hbcfg_ctrl.sv
module hbcfg_ctrl
  import hbcfg_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          apWrValid,
  input  logic [31:0]   apWdata,
  output logic          apReady,
  input  logic          extPresent,
  output logic          extReqValid,
  input  logic          extReqReady,
  output logic [31:0]   extReqData,
  input  logic          extRspValid,
  input  logic          dirValid,
  input  logic          dirWrite,
  input  logic          dpValid,
  input  logic          dpWrite,
  output strobe_t       stb,
  output logic [AW-1:0] ptrLoad
);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;

  state_e      state;
  logic [31:0] reqData;
  logic        apAccept;
  logic        isLocal;

  assign apReady     = (state == ST_IDLE);
  assign apAccept    = apWrValid && apReady;
  assign isLocal     = (apWdata[23:0] == LOCAL_TAG);
  assign ptrLoad     = apWdata[24 +: AW];
  assign extReqValid = (state == ST_REQ);
  assign extReqData  = reqData;

  always_comb begin
    stb              = '0;
    stb.latchPtr     = apAccept && isLocal;
    stb.loadFromRegs = apAccept && isLocal;
    stb.loadAllOnes  = apAccept && !isLocal && !extPresent;
    stb.loadFromRsp  = (state == ST_WAIT) && extRspValid;
    stb.dirWr        = dirValid && dirWrite;
    stb.dpWr         = dpValid && dpWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqData <= '0;
    end else begin
      case (state)
        ST_IDLE: if (apAccept && !isLocal && extPresent) begin
          reqData <= bswap32(apWdata);
          state   <= ST_REQ;
        end
        ST_REQ:  if (extReqReady) state <= ST_WAIT;
        ST_WAIT: if (extRspValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hbcfg_dpath.sv
module hbcfg_dpath
  import hbcfg_pkg::*;
#(
  parameter  int REG_BYTES = 256,
  localparam int AW        = $clog2(REG_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          variantSel,
  input  strobe_t       stb,
  input  logic [AW-1:0] ptrLoad,
  input  logic [31:0]   rspData,
  input  logic [1:0]    dirSize,
  input  logic [AW-1:0] dirAddr,
  input  logic [31:0]   dirWdata,
  output logic [31:0]   dirRdata,
  input  logic [1:0]    dpSize,
  input  logic [1:0]    dpSub,
  input  logic [31:0]   dpWdata,
  output logic [31:0]   dpRdata
);

  logic [7:0]    regFile [REG_BYTES];
  logic [7:0]    dataBuf [BUF_BYTES];
  logic [AW-1:0] ptr;

  int            dirNb;
  int            dpNb;
  logic [AW-1:0] dirBase;
  logic [1:0]    subBase;
  logic [AW-1:0] dpBase;
  logic [31:0]   rspSwap;

  assign dirNb   = laneCount(dirSize);
  assign dpNb    = laneCount(dpSize);
  assign dirBase = dirAddr & ~AW'(dirNb - 1);
  assign subBase = dpSub & ~2'(dpNb - 1);
  assign dpBase  = ptr + AW'(subBase);
  assign rspSwap = bswap32(rspData);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_BYTES; i++) regFile[i] <= resetByte(variantSel, i);
      for (int k = 0; k < BUF_BYTES; k++) dataBuf[k] <= 8'h00;
      ptr <= '0;
    end else begin
      if (stb.dirWr)
        for (int k = 0; k < BUF_BYTES; k++)
          if (k < dirNb) regFile[dirBase + AW'(k)] <= laneByte(dirWdata, dirSize, k);
      if (stb.dpWr)
        for (int k = 0; k < BUF_BYTES; k++)
          if (k < dpNb) begin
            regFile[dpBase + AW'(k)]   <= laneByte(dpWdata, dpSize, k);
            dataBuf[subBase + 2'(k)]   <= laneByte(dpWdata, dpSize, k);
          end
      if (stb.latchPtr) ptr <= ptrLoad;
      if (stb.loadFromRegs)
        for (int k = 0; k < BUF_BYTES; k++) dataBuf[k] <= regFile[ptrLoad + AW'(k)];
      else if (stb.loadFromRsp)
        for (int k = 0; k < BUF_BYTES; k++) dataBuf[k] <= rspSwap[31-8*k -: 8];
      else if (stb.loadAllOnes)
        for (int k = 0; k < BUF_BYTES; k++) dataBuf[k] <= 8'hFF;
    end
  end

  always_comb begin
    dirRdata = '0;
    for (int k = 0; k < BUF_BYTES; k++)
      if (k < dirNb) dirRdata[8*(dirNb-1-k) +: 8] = regFile[dirBase + AW'(k)];
  end

  always_comb begin
    dpRdata = '0;
    for (int k = 0; k < BUF_BYTES; k++)
      if (k < dpNb) dpRdata[8*(dpNb-1-k) +: 8] = dataBuf[subBase + 2'(k)];
  end

endmodule

// File: rtl/hbcfg_port.sv
module hbcfg_port
  import hbcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        variantSel,
  input  logic        dirValid,
  input  logic        dirWrite,
  input  logic [1:0]  dirSize,
  input  logic [7:0]  dirAddr,
  input  logic [31:0] dirWdata,
  output logic [31:0] dirRdata,
  input  logic        apWrValid,
  input  logic [31:0] apWdata,
  output logic        apReady,
  input  logic        dpValid,
  input  logic        dpWrite,
  input  logic [1:0]  dpSize,
  input  logic [1:0]  dpSub,
  input  logic [31:0] dpWdata,
  output logic [31:0] dpRdata,
  input  logic        extPresent,
  output logic        extReqValid,
  input  logic        extReqReady,
  output logic [31:0] extReqData,
  input  logic        extRspValid,
  input  logic [31:0] extRspData
);

  localparam int REG_BYTES = 256;
  localparam int AW        = $clog2(REG_BYTES);

  strobe_t       stb;
  logic [AW-1:0] ptrLoad;

  hbcfg_ctrl #(.AW(AW)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .apWrValid  (apWrValid),
    .apWdata    (apWdata),
    .apReady    (apReady),
    .extPresent (extPresent),
    .extReqValid(extReqValid),
    .extReqReady(extReqReady),
    .extReqData (extReqData),
    .extRspValid(extRspValid),
    .dirValid   (dirValid),
    .dirWrite   (dirWrite),
    .dpValid    (dpValid),
    .dpWrite    (dpWrite),
    .stb        (stb),
    .ptrLoad    (ptrLoad)
  );

  hbcfg_dpath #(.REG_BYTES(REG_BYTES)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .variantSel(variantSel),
    .stb       (stb),
    .ptrLoad   (ptrLoad),
    .rspData   (extRspData),
    .dirSize   (dirSize),
    .dirAddr   (dirAddr),
    .dirWdata  (dirWdata),
    .dirRdata  (dirRdata),
    .dpSize    (dpSize),
    .dpSub     (dpSub),
    .dpWdata   (dpWdata),
    .dpRdata   (dpRdata)
  );

endmodule

// File: rtl/hbcfg_port_chk.sv
module hbcfg_port_chk (
  input logic        clk,
  input logic        rstN,
  input logic        dirSize0,
  input logic [1:0]  dirSize,
  input logic [31:0] dirRdata,
  input logic        apWrValid,
  input logic [31:0] apWdata,
  input logic        apReady,
  input logic        dpValid,
  input logic        dpWrite,
  input logic [1:0]  dpSize,
  input logic [31:0] dpRdata,
  input logic        extPresent,
  input logic        extReqValid,
  input logic        extReqReady,
  input logic [31:0] extReqData,
  input logic        extRspValid,
  input logic [31:0] extRspData
);

  logic apTake;
  logic tagLocal;
  assign apTake   = apWrValid && apReady;
  assign tagLocal = (apWdata[23:0] == 24'h000080);

  // R7: an offered request holds until taken
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    extReqValid && !extReqReady |=> extReqValid && $stable(extReqData));

  // R7: forwarded word appears byte-reversed
  assert_fwd_swap_R7: assert property (@(posedge clk) disable iff (!rstN)
    apTake && !tagLocal && extPresent |=>
      extReqValid && extReqData == {$past(apWdata[7:0]), $past(apWdata[15:8]),
                                    $past(apWdata[23:16]), $past(apWdata[31:24])});

  // R10: address port is busy while a request is offered
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    extReqValid |-> !apReady);

  // R4: internal access raises no request
  assert_local_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    apTake && tagLocal && !(dpValid && dpWrite) |=> !extReqValid && apReady);

  // R9: absent responder yields all ones
  assert_absent_ones_R9: assert property (@(posedge clk) disable iff (!rstN)
    apTake && !tagLocal && !extPresent |=>
      !extReqValid && (dpSize != 2'd2 || dpRdata == 32'hFFFF_FFFF));

  // R8: reply lands byte-reversed and frees the port
  assert_rsp_load_R8: assert property (@(posedge clk) disable iff (!rstN)
    extRspValid && !apReady && !extReqValid |=>
      apReady && (dpSize != 2'd2 ||
        dpRdata == {$past(extRspData[7:0]), $past(extRspData[15:8]),
                    $past(extRspData[23:16]), $past(extRspData[31:24])}));

  // R3: byte reads leave the upper bits clear
  assert_byte_zext_R3: assert property (@(posedge clk) disable iff (!rstN)
    dirSize0 |-> dirRdata[31:8] == 24'h0);

endmodule

bind hbcfg_port hbcfg_port_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .dirSize0   (dirSize == 2'd0),
  .dirSize    (dirSize),
  .dirRdata   (dirRdata),
  .apWrValid  (apWrValid),
  .apWdata    (apWdata),
  .apReady    (apReady),
  .dpValid    (dpValid),
  .dpWrite    (dpWrite),
  .dpSize     (dpSize),
  .dpRdata    (dpRdata),
  .extPresent (extPresent),
  .extReqValid(extReqValid),
  .extReqReady(extReqReady),
  .extReqData (extReqData),
  .extRspValid(extRspValid),
  .extRspData (extRspData)
);

// File: tb/test_hbcfg_port.sv
module test_hbcfg_port;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        variantSel = 1'b0;
  logic        dirValid = 1'b0, dirWrite = 1'b0;
  logic [1:0]  dirSize = 2'd0;
  logic [7:0]  dirAddr = 8'h00;
  logic [31:0] dirWdata = '0;
  logic [31:0] dirRdata;
  logic        apWrValid = 1'b0;
  logic [31:0] apWdata = '0;
  logic        apReady;
  logic        dpValid = 1'b0, dpWrite = 1'b0;
  logic [1:0]  dpSize = 2'd0, dpSub = 2'd0;
  logic [31:0] dpWdata = '0;
  logic [31:0] dpRdata;
  logic        extPresent = 1'b1;
  logic        extReqValid;
  logic        extReqReady = 1'b0;
  logic [31:0] extReqData;
  logic        extRspValid = 1'b0;
  logic [31:0] extRspData = '0;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  logic [7:0] model [256];
  logic [7:0] mbuf  [4];
  logic [7:0] mptr;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbcfg_port i_hbcfg_port (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nbOf(logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] imgByte(bit vb, int a);
    logic [7:0] v;
    v = 8'h00;
    if (a == 0) v = 8'h10;
    if (a == 1) v = 8'h57;
    if (a == 3) v = vb ? 8'h02 : 8'h01;
    if (a == 5) v = 8'h06;
    if (a == 7) v = 8'h80;
    if (a == 11) v = 8'h06;
    if (a == 240) v = 8'hFF;
    if (a == 241) v = 8'h02;
    if (vb) begin
      if (a == 12) v = 8'h08;
      if (a == 115) v = 8'hCD;
      if (a == 224) v = 8'h0F;
      if (a == 225) v = 8'hFF;
      if (a == 227) v = 8'h42;
      if (a == 235) v = 8'h20;
    end
    return v;
  endfunction

  function automatic logic [31:0] modelRead(logic [1:0] sz, logic [7:0] a);
    int nb;
    logic [31:0] r;
    nb = nbOf(sz);
    r = 0;
    for (int k = 0; k < nb; k++)
      r = (r << 8) | 32'(model[8'((int'(a) / nb) * nb + k)]);
    return r;
  endfunction

  function automatic logic [31:0] bufRead(logic [1:0] sz, logic [1:0] s);
    int nb;
    logic [31:0] r;
    nb = nbOf(sz);
    r = 0;
    for (int k = 0; k < nb; k++)
      r = (r << 8) | 32'(mbuf[(int'(s) / nb) * nb + k]);
    return r;
  endfunction

  task automatic doReset(bit vb);
    @(negedge clk);
    variantSel = vb;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int a = 0; a < 256; a++) model[a] = imgByte(vb, a);
    for (int k = 0; k < 4; k++) mbuf[k] = 8'h00;
    mptr = 8'h00;
  endtask

  task automatic dirWr(logic [1:0] sz, logic [7:0] a, logic [31:0] d);
    int nb;
    @(negedge clk);
    dirValid = 1; dirWrite = 1; dirSize = sz; dirAddr = a; dirWdata = d;
    @(negedge clk);
    dirValid = 0; dirWrite = 0;
    nb = nbOf(sz);
    for (int k = 0; k < nb; k++)
      model[8'((int'(a) / nb) * nb + k)] = d[8*(nb-1-k) +: 8];
  endtask

  task automatic dirChk(string req, logic [1:0] sz, logic [7:0] a);
    @(negedge clk);
    dirSize = sz; dirAddr = a;
    #1;
    check(req, $sformatf("direct read sz%0d @%h", sz, a), dirRdata, modelRead(sz, a));
  endtask

  task automatic apWr(logic [31:0] d);
    @(negedge clk);
    apWrValid = 1; apWdata = d;
    @(negedge clk);
    apWrValid = 0;
  endtask

  task automatic apLocal(logic [7:0] off);
    apWr({off, 24'h000080});
    mptr = off;
    for (int k = 0; k < 4; k++) mbuf[k] = model[8'(off + 8'(k))];
  endtask

  task automatic dpWr(logic [1:0] sz, logic [1:0] s, logic [31:0] d);
    int nb, sb;
    @(negedge clk);
    dpValid = 1; dpWrite = 1; dpSize = sz; dpSub = s; dpWdata = d;
    @(negedge clk);
    dpValid = 0; dpWrite = 0;
    nb = nbOf(sz);
    sb = (int'(s) / nb) * nb;
    for (int k = 0; k < nb; k++) begin
      model[8'(mptr + 8'(sb + k))] = d[8*(nb-1-k) +: 8];
      mbuf[sb + k] = d[8*(nb-1-k) +: 8];
    end
  endtask

  task automatic dpChk(string req, logic [1:0] sz, logic [1:0] s);
    @(negedge clk);
    dpSize = sz; dpSub = s;
    #1;
    check(req, $sformatf("data port read sz%0d sub%0d", sz, s), dpRdata, bufRead(sz, s));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
    end
  end

  initial begin
    // variant 0 reset image and cleared buffer
    doReset(1'b0);
    dpChk("R11", 2'd2, 2'd0);
    for (int a = 0; a < 256; a += 4) dirChk("R1", 2'd2, 8'(a));
    dirChk("R3", 2'd1, 8'h01);
    dirChk("R3", 2'd1, 8'h03);
    dirChk("R3", 2'd0, 8'h0B);

    // variant 1 reset image
    doReset(1'b1);
    for (int a = 0; a < 256; a += 4) dirChk("R2", 2'd2, 8'(a));
    dirChk("R2", 2'd0, 8'h73);

    // direct writes of every size, then a full sweep of reads
    for (int a = 0; a < 256; a += 37) dirWr(2'd0, 8'(a), 32'(a ^ 8'h5A));
    dirWr(2'd2, 8'h13, 32'hDEADBEEF);
    dirWr(2'd2, 8'h82, 32'h01234567);
    dirWr(2'd1, 8'h45, 32'h0000C0DE);
    dirWr(2'd1, 8'hFF, 32'hFFFF7A7B);
    dirWr(2'd0, 8'hC7, 32'hFFFFFF99);
    for (int a = 0; a < 256; a++)
      for (int s = 0; s < 3; s++) dirChk("R3", 2'(s), 8'(a));

    // indirect reads over every offset, including the wrap past 0xFF
    for (int off = 0; off < 256; off++) begin
      apLocal(8'(off));
      dpChk("R4", 2'd2, 2'd0);
      if (off % 16 == 13) begin
        for (int s = 0; s < 4; s++) dpChk("R5", 2'd0, 2'(s));
        for (int s = 0; s < 4; s++) dpChk("R5", 2'd1, 2'(s));
      end
    end

    // data-port writes at several offsets, wrapping at the top
    apLocal(8'hFE);
    dpWr(2'd2, 2'd3, 32'hA0B1C2D3);
    dpChk("R6", 2'd2, 2'd0);
    dpWr(2'd1, 2'd3, 32'h00004E4F);
    dpChk("R6", 2'd2, 2'd0);
    dpWr(2'd0, 2'd1, 32'h00000066);
    dpChk("R6", 2'd2, 2'd0);
    apLocal(8'h40);
    dpWr(2'd0, 2'd2, 32'h000000E7);
    dpWr(2'd1, 2'd0, 32'h0000F00D);
    dpChk("R6", 2'd2, 2'd0);
    for (int a = 0; a < 256; a += 4) dirChk("R6", 2'd2, 8'(a));

    // forwarded request with a slow responder
    apLocal(8'h20);
    extPresent = 1;
    apWr(32'h12345678);
    #1;
    check("R7", "request valid", 32'(extReqValid), 32'd1);
    check("R7", "request data swapped", extReqData, 32'h78563412);
    check("R10", "port busy", 32'(apReady), 32'd0);
    // a local write while busy must be ignored
    apWr(32'h90000080);
    @(negedge clk);
    check("R7", "request held", extReqData, 32'h78563412);
    extReqReady = 1;
    @(negedge clk);
    extReqReady = 0;
    #1;
    check("R7", "request dropped after handshake", 32'(extReqValid), 32'd0);
    check("R10", "still busy waiting", 32'(apReady), 32'd0);
    apWr(32'h04000080);
    extRspValid = 1; extRspData = 32'hA1B2C3D4;
    @(negedge clk);
    extRspValid = 0;
    for (int k = 0; k < 4; k++) mbuf[k] = 8'(32'hD4C3B2A1 >> (24 - 8*k));
    #1;
    check("R8", "port ready after reply", 32'(apReady), 32'd1);
    dpChk("R8", 2'd2, 2'd0);
    dpChk("R8", 2'd0, 2'd0);
    // offset must still be 0x20: ignored writes left it alone
    dpWr(2'd0, 2'd0, 32'h0000003C);
    dirChk("R10", 2'd0, 8'h20);
    dirChk("R10", 2'd0, 8'h90);
    dirChk("R10", 2'd0, 8'h04);

    // no responder attached
    extPresent = 0;
    apWr(32'h00000081);
    #1;
    check("R9", "no request raised", 32'(extReqValid), 32'd0);
    for (int k = 0; k < 4; k++) mbuf[k] = 8'hFF;
    dpChk("R9", 2'd2, 2'd0);
    dpChk("R9", 2'd1, 2'd2);
    check("R9", "port ready", 32'(apReady), 32'd1);

    finished = 1;
    finish_run();
  end

endmodule